// File: doc/BRIEF.md
# Memory-Mapped Event Counter Unit

This block is a bank of eight 64-bit event counters behind a 64-bit register port with a valid/ready handshake. Each counter has an 8-bit event code that picks one strobe from the `ev_i` vector. Code zero makes the counter count every clock cycle instead. A counter advances only when the unit-wide run bit and its own enable bit are both set.

Counter enables and interrupt enables are changed through paired write-one-to-set and write-one-to-clear addresses, so software never needs a read-modify-write. When a counter wraps from all ones to zero, it sets a sticky overflow bit. Software clears overflow bits by writing ones. A single level interrupt line is raised while any overflow bit is set and its interrupt enable is also set.

The register port is run by a two-state machine:
- `ST_IDLE` holds `req_ready` high. An accepted request moves it to `ST_RESP`.
- `ST_RESP` drives `rsp_valid` for exactly one cycle with the read data, or zero after a write. It always returns to `ST_IDLE`.

Register writes take effect at the edge that accepts the request.

Top module: `evcnt_unit`

## Requirements
- R1: After reset, all counters, counter enables, interrupt enables, overflow bits and event codes are zero. The run bit is off and `irq_o` is low.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both high. In the next cycle `rsp_valid` is high for one cycle with the read data, and `req_ready` is low during that cycle.
- R3: Counter n is read and written as a full 64-bit value at byte offset 8·n. A write to a counter takes priority over an increment in the same cycle.
- R4: The event code of counter n sits in the low 8 bits of offset 0x200 + 8·n. Higher bits are dropped. Code 0x00 counts every clock edge.
- R5: A nonzero code c below NUM_EV (default 160) counts the edges where `ev_i[c]` is high. Codes at or above NUM_EV never count.
- R6: Counting requires both bit 0 (run) of the control register at 0x400 and the counter's own enable bit.
- R7: Writing 1 to bit 1 of 0x400 zeroes every counter. That bit reads back as 0, and bit 0 of the same write sets the run bit.
- R8: Ones written to 0x410 set counter-enable bits, and ones written to 0x418 clear them. Zero bits have no effect. Reads of both addresses return the enable mask (bit n is counter n).
- R9: Ones written to 0x420 set interrupt-enable bits, and ones written to 0x428 clear them. Reads of both return the mask.
- R10: A wrap from all ones to zero sets bit n of the overflow register at 0x440 on the same edge. The bit stays set until a one is written to it.
- R11: If a clear of an overflow bit and a new wrap of that counter fall on the same edge, the bit stays set.
- R12: `irq_o` is high exactly when some overflow bit and its interrupt-enable bit are both set.
- R13: The per-counter control slots at 0x100 + 8·n and all undecoded addresses read as zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (ST_IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response cycle (ST_RESP) |
| rsp_rdata | output | 64 | Read data, zero after a write |
| ev_i | input | NUM_EV | Event strobes indexed by event code |
| irq_o | output | 1 | Level interrupt |

## Verification
Counting is tried in three ways, each with a count the bench knows in advance:
- Code zero runs for a known span of edges. The result shows that cycles are counted and that enable timing is edge-exact.
- A fixed strobe pattern drives one selected code while every other strobe is held high. This separates correct selection from any leakage of neighbouring strobes or unmapped codes.
- The same pulses are repeated with the run bit off. This separates the unit-wide gate from the per-counter gate.

Counters preloaded two below wrap place an overflow on a known edge. One such overflow lines up with a software clear to show which of the two wins.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
    localparam int ADDR_W  = 12;
    localparam int REGION_LSB = 8;
    localparam int WORD_LSB   = 3;

    // address regions selected by req_addr[ADDR_W-1:REGION_LSB]
    localparam int REGION_CNT = 0;
    localparam int REGION_CTL = 1;
    localparam int REGION_SEL = 2;

    localparam logic [ADDR_W-1:0] OFF_GCTRL  = 12'h400;
    localparam logic [ADDR_W-1:0] OFF_EN_SET = 12'h410;
    localparam logic [ADDR_W-1:0] OFF_EN_CLR = 12'h418;
    localparam logic [ADDR_W-1:0] OFF_IE_SET = 12'h420;
    localparam logic [ADDR_W-1:0] OFF_IE_CLR = 12'h428;
    localparam logic [ADDR_W-1:0] OFF_OVF    = 12'h440;

    localparam int GC_RUN  = 0;
    localparam int GC_ZERO = 1;

    typedef enum logic {ST_IDLE, ST_RESP} bus_state_e;
endpackage

// File: rtl/evcnt_slice.sv
module evcnt_slice #(
    parameter int CTR_W  = 64,
    parameter int SEL_W  = 8,
    parameter int NUM_EV = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic             wr_en,
    input  logic [CTR_W-1:0] wr_data,
    input  logic             zero_all,
    output logic [CTR_W-1:0] count,
    output logic             wrap
);
    localparam int EV_SPACE = 1 << SEL_W;

    logic [EV_SPACE-1:0] ev_pad;
    logic                hit;
    logic                inc;

    always_comb begin
        ev_pad    = EV_SPACE'(ev_i);
        ev_pad[0] = 1'b1;          // code zero: every cycle
        hit       = ev_pad[sel];
    end

    assign inc  = run && hit && !wr_en && !zero_all;
    assign wrap = inc && (&count);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        count <= '0;
        else if (zero_all) count <= '0;
        else if (wr_en)    count <= wr_data;
        else if (inc)      count <= count + 1'b1;
    end
endmodule

// File: rtl/evcnt_bus_fsm.sv
module evcnt_bus_fsm
    import evcnt_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] rd_next,
    output logic              req_ready,
    output logic              accept,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    bus_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        accept    = req_ready && req_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (accept) rsp_rdata <= req_write ? '0 : rd_next;
    end
endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit
    import evcnt_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int DATA_W  = 64,
    parameter int SEL_W   = 8,
    parameter int NUM_EV  = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [NUM_EV-1:0] ev_i,
    output logic              irq_o
);
    localparam int REGION_W = ADDR_W - REGION_LSB;
    localparam int SLOT_W   = REGION_LSB - WORD_LSB;

    logic                    accept, wr_acc;
    logic [REGION_W-1:0]     region;
    logic [SLOT_W-1:0]       slot;
    logic [ADDR_W-WORD_LSB-1:0] waddr;
    logic [DATA_W-1:0]       rd_next;

    logic                    glb_en;
    logic [NUM_CTR-1:0]      cnt_en, int_en, ovf_q;
    logic [NUM_CTR-1:0]      cnt_wr, sel_wr, wrap, ovf_clr;
    logic [SEL_W-1:0]        evsel [NUM_CTR];
    logic [NUM_CTR-1:0][DATA_W-1:0] cnt_q;
    logic                    zero_all;
    logic                    hit_gctrl, hit_en_set, hit_en_clr;
    logic                    hit_ie_set, hit_ie_clr, hit_ovf;

    evcnt_bus_fsm #(.DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .rd_next(rd_next), .req_ready(req_ready), .accept(accept),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    assign wr_acc = accept && req_write;
    assign region = req_addr[ADDR_W-1:REGION_LSB];
    assign slot   = req_addr[REGION_LSB-1:WORD_LSB];
    assign waddr  = req_addr[ADDR_W-1:WORD_LSB];

    assign hit_gctrl  = (waddr == OFF_GCTRL[ADDR_W-1:WORD_LSB]);
    assign hit_en_set = (waddr == OFF_EN_SET[ADDR_W-1:WORD_LSB]);
    assign hit_en_clr = (waddr == OFF_EN_CLR[ADDR_W-1:WORD_LSB]);
    assign hit_ie_set = (waddr == OFF_IE_SET[ADDR_W-1:WORD_LSB]);
    assign hit_ie_clr = (waddr == OFF_IE_CLR[ADDR_W-1:WORD_LSB]);
    assign hit_ovf    = (waddr == OFF_OVF[ADDR_W-1:WORD_LSB]);

    assign zero_all = wr_acc && hit_gctrl && req_wdata[GC_ZERO];
    assign ovf_clr  = (wr_acc && hit_ovf) ? req_wdata[NUM_CTR-1:0] : '0;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        assign cnt_wr[i] = wr_acc && (int'(region) == REGION_CNT) && (int'(slot) == i);
        assign sel_wr[i] = wr_acc && (int'(region) == REGION_SEL) && (int'(slot) == i);

        evcnt_slice #(.CTR_W(DATA_W), .SEL_W(SEL_W), .NUM_EV(NUM_EV)) u_slice (
            .clk(clk), .rst_n(rst_n), .run(glb_en && cnt_en[i]), .sel(evsel[i]),
            .ev_i(ev_i), .wr_en(cnt_wr[i]), .wr_data(req_wdata),
            .zero_all(zero_all), .count(cnt_q[i]), .wrap(wrap[i])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         evsel[i] <= '0;
            else if (sel_wr[i]) evsel[i] <= req_wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_en <= 1'b0;
            cnt_en <= '0;
            int_en <= '0;
            ovf_q  <= '0;
        end else begin
            if (wr_acc && hit_gctrl)  glb_en <= req_wdata[GC_RUN];
            if (wr_acc && hit_en_set) cnt_en <= cnt_en | req_wdata[NUM_CTR-1:0];
            if (wr_acc && hit_en_clr) cnt_en <= cnt_en & ~req_wdata[NUM_CTR-1:0];
            if (wr_acc && hit_ie_set) int_en <= int_en | req_wdata[NUM_CTR-1:0];
            if (wr_acc && hit_ie_clr) int_en <= int_en & ~req_wdata[NUM_CTR-1:0];
            ovf_q <= (ovf_q & ~ovf_clr) | wrap;
        end
    end

    assign irq_o = |(ovf_q & int_en);

    always_comb begin
        rd_next = '0;
        if (int'(region) == REGION_CNT) begin
            for (int i = 0; i < NUM_CTR; i++)
                if (int'(slot) == i) rd_next = cnt_q[i];
        end else if (int'(region) == REGION_SEL) begin
            for (int i = 0; i < NUM_CTR; i++)
                if (int'(slot) == i) rd_next = DATA_W'(evsel[i]);
        end else if (hit_gctrl) begin
            rd_next = DATA_W'(glb_en);
        end else if (hit_en_set || hit_en_clr) begin
            rd_next = DATA_W'(cnt_en);
        end else if (hit_ie_set || hit_ie_clr) begin
            rd_next = DATA_W'(int_en);
        end else if (hit_ovf) begin
            rd_next = DATA_W'(ovf_q);
        end
    end
endmodule

// File: rtl/evcnt_unit_chk.sv
module evcnt_unit_chk #(
    parameter int NUM_CTR = 8,
    parameter int DATA_W  = 64
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic                          rsp_valid,
    input logic                          irq_o,
    input logic                          glb_en,
    input logic [NUM_CTR-1:0]            cnt_en,
    input logic [NUM_CTR-1:0]            int_en,
    input logic [NUM_CTR-1:0]            ovf_q,
    input logic [NUM_CTR-1:0]            ovf_clr,
    input logic [NUM_CTR-1:0]            wrap,
    input logic [NUM_CTR-1:0]            cnt_wr,
    input logic                          zero_all,
    input logic [NUM_CTR-1:0][DATA_W-1:0] cnt_q
);
    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    p_busy_in_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    p_irq_needs_ovf_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ovf_q != '0));
    p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == '0) |-> !irq_o);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        p_wrap_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[i] |=> ovf_q[i]);
        p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_q[i] && !ovf_clr[i]) |=> ovf_q[i]);
        p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (wrap[i] && ovf_clr[i]) |=> ovf_q[i]);
        p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!(glb_en && cnt_en[i]) && !cnt_wr[i] && !zero_all) |=> $stable(cnt_q[i]));
        p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            zero_all |=> (cnt_q[i] == '0));
    end
endmodule

bind evcnt_unit evcnt_unit_chk #(.NUM_CTR(NUM_CTR), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .irq_o(irq_o), .glb_en(glb_en), .cnt_en(cnt_en),
    .int_en(int_en), .ovf_q(ovf_q), .ovf_clr(ovf_clr), .wrap(wrap),
    .cnt_wr(cnt_wr), .zero_all(zero_all), .cnt_q(cnt_q)
);

// File: tb/evcnt_unit_tb.sv
module evcnt_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [159:0] ev = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evcnt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ev_i(ev), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
        @(posedge clk);
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        d = rsp_rdata;
        @(posedge clk);
    endtask

    task automatic expect_rd(input string tag, input logic [11:0] a, input logic [63:0] exp);
        logic [63:0] d;
        bus_rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic t_reset;
        expect_rd("R1 ctrl", 12'h400, 64'h0);
        expect_rd("R1 counter0", 12'h000, 64'h0);
        expect_rd("R1 enables", 12'h410, 64'h0);
        expect_rd("R1 evsel7", 12'h238, 64'h0);
        check("R1 irq", {63'h0, irq_o}, 64'h0);
    endtask

    task automatic t_handshake;
        @(negedge clk);
        check("R2 ready idle", {63'h0, req_ready}, 64'h1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h400;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 rsp_valid", {63'h0, rsp_valid}, 64'h1);
        check("R2 ready low in resp", {63'h0, req_ready}, 64'h0);
        @(posedge clk);
        @(negedge clk);
        check("R2 rsp one cycle", {63'h0, rsp_valid}, 64'h0);
    endtask

    task automatic t_enables;
        bus_wr(12'h410, 64'h01);
        bus_wr(12'h410, 64'h02);
        expect_rd("R8 set accumulates", 12'h410, 64'h03);
        bus_wr(12'h418, 64'h01);
        expect_rd("R8 clear via clr addr", 12'h418, 64'h02);
        bus_wr(12'h418, 64'hFF);
        expect_rd("R8 clear all", 12'h410, 64'h00);
        bus_wr(12'h420, 64'h81);
        bus_wr(12'h428, 64'h01);
        expect_rd("R9 int enable mask", 12'h420, 64'h80);
        bus_wr(12'h428, 64'hFF);
        expect_rd("R9 int clear all", 12'h428, 64'h00);
    endtask

    task automatic t_cycles;
        bus_wr(12'h400, 64'h1);
        bus_wr(12'h410, 64'h01);
        repeat (5) @(posedge clk);
        bus_wr(12'h418, 64'h01);
        expect_rd("R4 cycle count", 12'h000, 64'd7);
        bus_wr(12'h208, 64'hFFFF_FF10);
        expect_rd("R4 evsel low byte", 12'h208, 64'h10);
    endtask

    task automatic t_events;
        logic [9:0] pat = 10'b10_1100_1110;
        bus_wr(12'h210, 64'h20);
        bus_wr(12'h230, 64'hF0);
        bus_wr(12'h410, 64'h46);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ev = '1;
            ev[8'h20] = 1'b0;
            ev[8'h10] = pat[i];
        end
        @(negedge clk);
        ev = '0;
        bus_wr(12'h418, 64'hFF);
        expect_rd("R5 selected strobe", 12'h008, 64'd6);
        expect_rd("R5 quiet strobe", 12'h010, 64'd0);
        expect_rd("R5 unmapped code", 12'h030, 64'd0);
    endtask

    task automatic t_gate;
        bus_wr(12'h400, 64'h0);
        bus_wr(12'h410, 64'h02);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            ev[8'h10] = 1'b1;
        end
        @(negedge clk);
        ev = '0;
        bus_wr(12'h418, 64'h02);
        expect_rd("R6 run bit off holds", 12'h008, 64'd6);
        bus_wr(12'h008, 64'h1234_5678_9ABC_DEF0);
        expect_rd("R3 counter write", 12'h008, 64'h1234_5678_9ABC_DEF0);
    endtask

    task automatic t_zero;
        bus_wr(12'h400, 64'h3);
        expect_rd("R7 counters zeroed", 12'h008, 64'd0);
        expect_rd("R7 counter0 zeroed", 12'h000, 64'd0);
        expect_rd("R7 zero bit reads 0", 12'h400, 64'h1);
    endtask

    task automatic t_overflow;
        bus_wr(12'h018, 64'hFFFF_FFFF_FFFF_FFFE);
        bus_wr(12'h420, 64'h08);
        bus_wr(12'h410, 64'h08);
        bus_wr(12'h418, 64'h08);
        expect_rd("R10 wrapped to zero", 12'h018, 64'd0);
        expect_rd("R10 overflow bit", 12'h440, 64'h08);
        check("R12 irq raised", {63'h0, irq_o}, 64'h1);
        bus_wr(12'h428, 64'h08);
        @(negedge clk);
        check("R12 irq masked", {63'h0, irq_o}, 64'h0);
        expect_rd("R10 status sticky", 12'h440, 64'h08);
        bus_wr(12'h420, 64'h08);
        bus_wr(12'h440, 64'h08);
        expect_rd("R10 w1c cleared", 12'h440, 64'h00);
        check("R12 irq dropped", {63'h0, irq_o}, 64'h0);
    endtask

    task automatic t_set_wins;
        bus_wr(12'h028, 64'hFFFF_FFFF_FFFF_FFFE);
        bus_wr(12'h410, 64'h20);
        bus_wr(12'h440, 64'h20);
        bus_wr(12'h418, 64'h20);
        expect_rd("R11 set beats clear", 12'h440, 64'h20);
        bus_wr(12'h440, 64'h20);
        expect_rd("R11 later clear", 12'h440, 64'h00);
    endtask

    task automatic t_undecoded;
        bus_wr(12'h100, 64'hFFFF);
        bus_wr(12'h300, 64'hFFFF);
        bus_wr(12'h600, 64'hFF);
        bus_wr(12'h438, 64'hFF);
        expect_rd("R13 ctl slot", 12'h100, 64'h0);
        expect_rd("R13 hole 0x300", 12'h300, 64'h0);
        expect_rd("R13 hole 0x600", 12'h600, 64'h0);
        expect_rd("R13 enables untouched", 12'h410, 64'h0);
        expect_rd("R13 run untouched", 12'h400, 64'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_handshake;
        t_enables;
        t_cycles;
        t_events;
        t_gate;
        t_zero;
        t_overflow;
        t_set_wins;
        t_undecoded;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule